// File: doc/BRIEF.md
# Command Frame Serialiser

This block turns one command, given as a set of header fields plus a payload of 32-bit words, into a framed byte stream for a byte-wide transmit path. Each frame opens with an eight-byte header. The header holds a fixed sync value, the opcode, the chip and core addresses, a 16-bit argument, the payload size in words and a CRC-8 check byte. The payload bytes follow the header directly. A downstream byte sink paces the output with a valid/ready handshake.

A client offers a command on the command port. The payload words come through their own valid/ready port while the frame is being sent. The block samples a command only when it is idle. Once it has accepted a command, it accepts no other until the sink has taken the last byte of the frame. A command whose byte length cannot be encoded (not a multiple of four, or larger than the maximum) is answered with a single-cycle error pulse, and no frame is sent. A typical use is a work command: a 56-byte payload, with the core address in the upper byte of the argument and a sequence number in the lower byte.

Top module: `cmd_frame_tx`

## Requirements
- R1: Frame byte 0 is 0xAA. Bytes 1, 2 and 3 are the opcode, the chip address and the core address.
- R2: Frame bytes 4 and 5 carry the 16-bit argument, low byte at position 4 and high byte at position 5.
- R3: Frame byte 6 is the payload byte length divided by four.
- R4: Frame byte 7 is a CRC-8 over bytes 1 to 6 only. Generator 0x07, register preset to 0x00, bits taken MSB first, no final inversion.
- R5: The payload follows the header with no gap in the byte order. Each word is sent least significant byte first. Exactly length/4 words are drawn from the payload port, and the frame is 8 + length bytes long.
- R6: A command whose length exceeds 1020 or is not a multiple of four raises cmd_err for exactly one cycle, in the cycle after the one in which it was offered. No byte is emitted, and the block stays ready.
- R7: cmd_ready is high only while the block is idle with no byte pending. It is low from the cycle after an accepted command until the cycle after the sink takes the final byte. pay_ready is never high while idle.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_byte holds its value.
- R9: A zero-length command produces the eight header bytes only and never raises pay_ready.
- R10: After reset, cmd_ready is 1 and out_valid, pay_ready and cmd_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_opcode | input | 8 | Opcode field |
| cmd_chip | input | 8 | Chip address field |
| cmd_core | input | 8 | Core address field |
| cmd_hdata | input | 16 | Header argument |
| cmd_len | input | LEN_W | Payload length in bytes |
| cmd_err | output | 1 | One-cycle pulse for a refused length |
| pay_valid | input | 1 | Payload word offered |
| pay_ready | output | 1 | Payload word taken this cycle when valid |
| pay_word | input | 32 | Payload word |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink takes the byte |
| out_byte | output | 8 | Output byte |

## Verification
A captured header field that is corrupt shows up as a wrong byte at the matching position within the first eight handshakes. A wrong CRC chain affects only position 7. A fault in the word counter or the byte index inside a word shows up as reordered payload bytes, a wrong word count at the end of the frame, or a cmd_ready that rises early or late. Each of these is seen at the first affected handshake. The reference model predicts every output byte and the ready and error levels on every cycle, under random sink stalls and random payload gaps. A divergence is therefore reported in the cycle it appears.

// File: rtl/cmdfrm_pkg.sv
package cmdfrm_pkg;

  localparam logic [7:0] SYNC_BYTE  = 8'hAA;
  localparam logic [7:0] CRC_POLY   = 8'h07;
  localparam int         HDR_BYTES  = 8;
  localparam int         HDR_IDX_W  = $clog2(HDR_BYTES);
  localparam int         WORD_BYTES = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_PAY  = 2'd2
  } frm_state_t;

  // One byte of CRC-8 update, MSB first, no reflection.
  function automatic logic [7:0] crc8_step(input logic [7:0] crc_in,
                                           input logic [7:0] data);
    logic [7:0] c;
    c = crc_in ^ data;
    for (int b = 0; b < 8; b++) begin
      c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/cmdfrm_hdr.sv
module cmdfrm_hdr
  import cmdfrm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [7:0]           opcode,
  input  logic [7:0]           chip,
  input  logic [7:0]           core,
  input  logic [15:0]          hdata,
  input  logic [CNT_W-1:0]     words,
  input  logic [HDR_IDX_W-1:0] sel,
  output logic [7:0]           sel_byte
);

  localparam int BODY_N = HDR_BYTES - 2;

  // body[k] is header position k+1 (the CRC-covered span).
  logic [7:0] body  [BODY_N];
  logic [7:0] chain [BODY_N+1];
  logic [7:0] hb    [HDR_BYTES];

  assign body[0] = opcode;
  assign body[1] = chip;
  assign body[2] = core;
  assign body[3] = hdata[7:0];
  assign body[4] = hdata[15:8];
  assign body[5] = 8'(words);

  assign chain[0] = 8'h00;
  for (genvar k = 0; k < BODY_N; k++) begin : g_crc
    assign chain[k+1] = crc8_step(chain[k], body[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < HDR_BYTES; i++) hb[i] <= 8'h00;
    end else if (load) begin
      hb[0] <= SYNC_BYTE;
      for (int i = 0; i < BODY_N; i++) hb[i+1] <= body[i];
      hb[HDR_BYTES-1] <= chain[BODY_N];
    end
  end

  assign sel_byte = hb[sel];

endmodule

// File: rtl/cmdfrm_unpack.sv
module cmdfrm_unpack #(
  parameter int NBYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic                  take,
  input  logic                  in_valid,
  input  logic [8*NBYTES-1:0]   in_word,
  output logic                  in_ready,
  output logic                  full,
  output logic                  word_end,
  output logic [7:0]            cur_byte
);

  localparam int BI_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic [8*NBYTES-1:0] hold;
  logic [BI_W-1:0]     bidx;

  assign in_ready = en && !full;
  assign word_end = (bidx == BI_W'(NBYTES - 1));
  assign cur_byte = hold[8*bidx +: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
      full <= 1'b0;
      bidx <= '0;
    end else if (in_valid && in_ready) begin
      hold <= in_word;
      full <= 1'b1;
      bidx <= '0;
    end else if (take) begin
      if (word_end) begin
        full <= 1'b0;
        bidx <= '0;
      end else begin
        bidx <= bidx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cmdfrm_ctl.sv
module cmdfrm_ctl
  import cmdfrm_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int MAX_BYTES = 1020,
  parameter int CNT_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [LEN_W-1:0]     cmd_len,
  output logic                 cmd_ready,
  output logic                 cmd_err,
  output logic                 hdr_load,
  output logic [CNT_W-1:0]     hdr_words,
  output logic [HDR_IDX_W-1:0] hdr_sel,
  input  logic [7:0]           hdr_byte,
  output logic                 unpk_en,
  output logic                 unpk_take,
  input  logic                 unpk_full,
  input  logic                 unpk_word_end,
  input  logic [7:0]           unpk_byte,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [7:0]           out_byte
);

  frm_state_t           st;
  logic [HDR_IDX_W-1:0] idx;
  logic [CNT_W-1:0]     nwords;
  logic [CNT_W-1:0]     wcnt;
  logic                 len_bad;
  logic                 accept;
  logic                 src_avail;
  logic                 load;
  logic [7:0]           src_byte;

  always_comb begin
    len_bad   = (cmd_len > LEN_W'(MAX_BYTES)) || (cmd_len[1:0] != 2'b00);
    cmd_ready = (st == ST_IDLE) && !out_valid;
    accept    = cmd_valid && cmd_ready;
    hdr_load  = accept && !len_bad;
    hdr_words = CNT_W'(cmd_len >> 2);
    hdr_sel   = idx;
    unpk_en   = (st == ST_PAY);
    src_avail = (st == ST_HDR) || ((st == ST_PAY) && unpk_full);
    src_byte  = (st == ST_HDR) ? hdr_byte : unpk_byte;
    load      = src_avail && (!out_valid || out_ready);
    unpk_take = load && (st == ST_PAY);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      idx       <= '0;
      nwords    <= '0;
      wcnt      <= '0;
      out_valid <= 1'b0;
      out_byte  <= 8'h00;
      cmd_err   <= 1'b0;
    end else begin
      cmd_err <= accept && len_bad;
      if (load) begin
        out_valid <= 1'b1;
        out_byte  <= src_byte;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      case (st)
        ST_IDLE: begin
          if (hdr_load) begin
            st     <= ST_HDR;
            idx    <= '0;
            nwords <= hdr_words;
            wcnt   <= '0;
          end
        end
        ST_HDR: begin
          if (load) begin
            idx <= idx + 1'b1;
            if (idx == HDR_IDX_W'(HDR_BYTES - 1)) begin
              st <= (nwords == '0) ? ST_IDLE : ST_PAY;
            end
          end
        end
        ST_PAY: begin
          if (load && unpk_word_end) begin
            wcnt <= wcnt + 1'b1;
            if (wcnt == CNT_W'(nwords - 1'b1)) st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cmd_frame_tx.sv
module cmd_frame_tx
  import cmdfrm_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int MAX_BYTES = 1020
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [7:0]       cmd_opcode,
  input  logic [7:0]       cmd_chip,
  input  logic [7:0]       cmd_core,
  input  logic [15:0]      cmd_hdata,
  input  logic [LEN_W-1:0] cmd_len,
  output logic             cmd_err,
  input  logic             pay_valid,
  output logic             pay_ready,
  input  logic [31:0]      pay_word,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_byte
);

  localparam int CNT_W = $clog2(MAX_BYTES / WORD_BYTES + 1);

  logic                 hdr_load;
  logic [CNT_W-1:0]     hdr_words;
  logic [HDR_IDX_W-1:0] hdr_sel;
  logic [7:0]           hdr_byte;
  logic                 unpk_en;
  logic                 unpk_take;
  logic                 unpk_full;
  logic                 unpk_word_end;
  logic [7:0]           unpk_byte;

  cmdfrm_ctl #(
    .LEN_W    (LEN_W),
    .MAX_BYTES(MAX_BYTES),
    .CNT_W    (CNT_W)
  ) u_ctl (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_len      (cmd_len),
    .cmd_ready    (cmd_ready),
    .cmd_err      (cmd_err),
    .hdr_load     (hdr_load),
    .hdr_words    (hdr_words),
    .hdr_sel      (hdr_sel),
    .hdr_byte     (hdr_byte),
    .unpk_en      (unpk_en),
    .unpk_take    (unpk_take),
    .unpk_full    (unpk_full),
    .unpk_word_end(unpk_word_end),
    .unpk_byte    (unpk_byte),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_byte     (out_byte)
  );

  cmdfrm_hdr #(
    .CNT_W(CNT_W)
  ) u_hdr (
    .clk     (clk),
    .rst     (rst),
    .load    (hdr_load),
    .opcode  (cmd_opcode),
    .chip    (cmd_chip),
    .core    (cmd_core),
    .hdata   (cmd_hdata),
    .words   (hdr_words),
    .sel     (hdr_sel),
    .sel_byte(hdr_byte)
  );

  cmdfrm_unpack #(
    .NBYTES(WORD_BYTES)
  ) u_unpk (
    .clk     (clk),
    .rst     (rst),
    .en      (unpk_en),
    .take    (unpk_take),
    .in_valid(pay_valid),
    .in_word (pay_word),
    .in_ready(pay_ready),
    .full    (unpk_full),
    .word_end(unpk_word_end),
    .cur_byte(unpk_byte)
  );

endmodule

// File: rtl/cmdfrm_chk.sv
module cmdfrm_chk #(
  parameter int LEN_W     = 11,
  parameter int MAX_BYTES = 1020
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [LEN_W-1:0] cmd_len,
  input logic             cmd_err,
  input logic             pay_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_byte
);

  logic off_bad;
  logic off_good;
  assign off_bad  = cmd_valid && cmd_ready &&
                    ((cmd_len > LEN_W'(MAX_BYTES)) || (cmd_len[1:0] != 2'b00));
  assign off_good = cmd_valid && cmd_ready && !off_bad;

  AST_SYNC_LEADS: assert property (@(posedge clk) disable iff (rst)
    off_good |=> ##1 (out_valid && out_byte == 8'hAA)); // R1

  AST_ERR_ON_BAD: assert property (@(posedge clk) disable iff (rst)
    off_bad |=> (cmd_err && !out_valid && cmd_ready)); // R6

  AST_ERR_ONLY_BAD: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> $past(off_bad)); // R6

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !cmd_ready); // R7

  AST_PAY_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    pay_ready |-> !cmd_ready); // R7

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte))); // R8

endmodule

bind cmd_frame_tx cmdfrm_chk #(
  .LEN_W    (LEN_W),
  .MAX_BYTES(MAX_BYTES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_len  (cmd_len),
  .cmd_err  (cmd_err),
  .pay_ready(pay_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_byte (out_byte)
);

// File: tb/tb_cmd_frame_tx.sv
module tb_cmd_frame_tx;

  localparam int LEN_W     = 11;
  localparam int MAX_BYTES = 1020;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [7:0]       cmd_opcode = '0;
  logic [7:0]       cmd_chip = '0;
  logic [7:0]       cmd_core = '0;
  logic [15:0]      cmd_hdata = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic             cmd_err;
  logic             pay_valid = 1'b0;
  logic             pay_ready;
  logic [31:0]      pay_word = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [7:0]       out_byte;

  always #2 clk = ~clk;

  cmd_frame_tx #(.LEN_W(LEN_W), .MAX_BYTES(MAX_BYTES)) dut (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_opcode(cmd_opcode), .cmd_chip(cmd_chip), .cmd_core(cmd_core),
    .cmd_hdata(cmd_hdata), .cmd_len(cmd_len), .cmd_err(cmd_err),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_word(pay_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte)
  );

  int checks = 0;
  int fails  = 0;
  bit started = 0;
  bit done = 0;

  logic [7:0]  exp_q[$];
  int          pos_q[$];
  logic [31:0] fw[$];
  int          pidx = 0;
  int          words_taken = 0;
  int          exp_words = 0;
  bit          busy = 0;
  bit          exp_err = 0;
  bit          acc_seen = 0;
  bit          prev_stall = 0;
  logic [7:0]  prev_byte = '0;
  int          rdy_mode = 0;
  int          pv_mode = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [7:0] bs[6]);
    logic [7:0] c;
    logic fb;
    c = 8'h00;
    for (int i = 0; i < 6; i++) begin
      for (int b = 7; b >= 0; b--) begin
        fb = c[7] ^ bs[i][b];
        c  = {c[6:0], 1'b0};
        if (fb) c = c ^ 8'h07;
      end
    end
    return c;
  endfunction

  function automatic string pos_tag(input int p);
    if (p < 4)  return "R1";
    if (p < 6)  return "R2";
    if (p == 6) return "R3";
    if (p == 7) return "R4";
    return "R5";
  endfunction

  // Reference model, evaluated mid-cycle on every clock.
  always @(negedge clk) begin
    if (started && !done) begin
      chk(cmd_ready == !busy, "R7", "cmd_ready", cmd_ready, !busy);
      chk(cmd_err == exp_err, "R6", "cmd_err", cmd_err, exp_err);
      if (prev_stall)
        chk(out_valid && out_byte == prev_byte, "R8", "held byte", out_byte, prev_byte);
      if (pay_ready && !busy) chk(0, "R7", "pay_ready while idle", 1, 0);
      if (pay_ready && busy && exp_words == 0) chk(0, "R9", "pay_ready on empty frame", 1, 0);
      if (out_valid && !busy) chk(0, "R6", "byte while idle", out_byte, 0);
      exp_err = 0;

      if (pay_valid && pay_ready) begin
        if (pidx >= fw.size()) chk(0, "R5", "extra word drawn", pidx, fw.size());
        pidx++;
        words_taken++;
      end

      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R5", "unexpected byte", out_byte, 0);
        end else begin
          logic [7:0] e;
          int p;
          e = exp_q.pop_front();
          p = pos_q.pop_front();
          chk(out_byte == e, pos_tag(p), $sformatf("byte %0d", p), out_byte, e);
          if (exp_q.size() == 0) begin
            chk(words_taken == exp_words, "R5", "words drawn", words_taken, exp_words);
            busy = 0;
          end
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_byte  = out_byte;

      if (cmd_valid && cmd_ready) begin
        int len;
        acc_seen = 1;
        len = int'(cmd_len);
        if (len > MAX_BYTES || (len % 4) != 0) begin
          exp_err = 1;
        end else begin
          logic [7:0] bs[6];
          bs[0] = cmd_opcode; bs[1] = cmd_chip; bs[2] = cmd_core;
          bs[3] = cmd_hdata[7:0]; bs[4] = cmd_hdata[15:8]; bs[5] = 8'(len / 4);
          exp_q.push_back(8'hAA); pos_q.push_back(0);
          for (int i = 0; i < 6; i++) begin
            exp_q.push_back(bs[i]); pos_q.push_back(i + 1);
          end
          exp_q.push_back(ref_crc(bs)); pos_q.push_back(7);
          for (int w = 0; w < fw.size(); w++) begin
            for (int b = 0; b < 4; b++) begin
              exp_q.push_back(fw[w][8*b +: 8]);
              pos_q.push_back(8 + 4*w + b);
            end
          end
          busy = 1;
          words_taken = 0;
          exp_words = len / 4;
        end
      end
    end
  end

  // Sink and payload source.
  always @(posedge clk) begin
    #1;
    out_ready = (rdy_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
    if (pidx < fw.size() && (pv_mode == 0 || ($urandom % 2) == 1)) begin
      pay_valid = 1'b1;
      pay_word  = fw[pidx];
    end else begin
      pay_valid = 1'b0;
      pay_word  = $urandom;
    end
  end

  task automatic send(input logic [7:0] op, input logic [7:0] ch, input logic [7:0] co,
                      input logic [15:0] hd, input int len);
    while (busy) @(posedge clk);
    @(posedge clk);
    #1;
    fw.delete();
    pidx = 0;
    if (len % 4 == 0 && len <= MAX_BYTES)
      for (int i = 0; i < len / 4; i++) fw.push_back($urandom);
    cmd_opcode = op; cmd_chip = ch; cmd_core = co; cmd_hdata = hd;
    cmd_len = LEN_W'(len);
    acc_seen = 0;
    cmd_valid = 1'b1;
    do @(posedge clk); while (!acc_seen);
    #1;
    cmd_valid = 1'b0;
    cmd_opcode = $urandom; cmd_len = LEN_W'($urandom);
  endtask

  task automatic drain();
    while (busy) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R7", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(cmd_ready == 1'b1, "R10", "cmd_ready after reset", cmd_ready, 1);
    chk(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
    chk(pay_ready == 1'b0, "R10", "pay_ready after reset", pay_ready, 0);
    chk(cmd_err == 1'b0, "R10", "cmd_err after reset", cmd_err, 0);
    started = 1;

    // R9 header-only frame
    send(8'h01, 8'h00, 8'h00, 16'h0000, 0);
    drain();
    send(8'h0C, 8'h12, 8'h34, 16'hBEEF, 8);
    drain();
    // work command: core in upper argument byte, sequence in lower
    send(8'h09, 8'h03, 8'h05, {8'h05, 8'h4D}, 56);
    drain();
    // R6 refused lengths
    send(8'h0B, 8'h00, 8'h00, 16'h0003, 1024);
    send(8'h0B, 8'h00, 8'h00, 16'h0003, 1022);
    send(8'h0B, 8'h00, 8'h00, 16'h0003, 2047);
    send(8'h0B, 8'h00, 8'h00, 16'h0003, 6);
    drain();
    // largest frame with stalls and gaps (R8, R5)
    rdy_mode = 1; pv_mode = 1;
    send(8'h80, 8'hFF, 8'hFF, 16'h0226, 1020);
    drain();
    rdy_mode = 0; pv_mode = 0;
    // back-to-back commands
    send(8'h0E, 8'h01, 8'h02, 16'h1234, 4);
    send(8'h0F, 8'h02, 8'h01, 16'h5678, 0);
    send(8'h10, 8'h07, 8'h08, 16'h9ABC, 12);
    drain();
    for (int n = 0; n < 12; n++) begin
      rdy_mode = n % 2;
      pv_mode  = (n / 2) % 2;
      send(8'($urandom), 8'($urandom), 8'($urandom), 16'($urandom), 4 * ($urandom % 51));
    end
    drain();
    chk(exp_q.size() == 0, "R5", "leftover expected bytes", exp_q.size(), 0);
    finish_run();
  end

endmodule